// File: doc/BRIEF.md
# Dual Event Counter Monitoring Unit

This block keeps two 40-bit event counters. Each counter has its own 3-bit event-count input, which gives the number of events seen in the current cycle. Each counter also has a select register that holds an 8-bit threshold. When the threshold is zero, the counter adds the full per-cycle count. When it is nonzero, the counter adds one in each cycle whose count reaches the threshold.

A small control state machine holds the global run state. It has two states:
- **HALT**: no counting.
- **RUN**: counter 0 counts, and counter 1 counts while its select register is nonzero.

It has two transitions:
- **HALT to RUN**: taken on a privileged write to select register 0 with the enable bit set.
- **RUN to HALT**: taken on a privileged write to select register 0 with the enable bit clear.

Counter presets are written as 32-bit values and sign-extended to 40 bits. A registered read port returns a counter value to privileged requests. It returns a value to user requests only while a user-access input allows it; otherwise the read faults.

Top module: `evm_top`

## Requirements
- R1: After reset both counters are zero, the machine is in HALT, and `rd_valid_o` and `rd_fault_o` are low.
- R2: In RUN with a threshold of zero, an active counter adds the value of its 3-bit event input on every clock edge.
- R3: The threshold is bits 31:24 of a select register. When it is nonzero, an active counter adds exactly one on an edge where its event input is greater than or equal to the threshold (unsigned compare), and holds otherwise.
- R4: The enable is bit 22 of select register 0, at write address 0. The edge that accepts a write setting it causes no count. Counting begins on the following edge. A write clearing it stops both counters.
- R5: While select register 1 (write address 1) holds all zeros, counter 1 holds its value and counter 0 is unaffected.
- R6: A write to address 2 (counter 0) or address 3 (counter 1) loads `wr_data_i` into bits 31:0 and copies bit 31 into bits 39:32. The write takes priority over that edge's increment.
- R7: A write with `wr_priv0_i` low has no effect on any counter, select register or run state.
- R8: A read (`rd_sel_i` 0 or 1) is accepted when `rd_priv0_i` is high or `user_rd_allow_i` is high. One cycle later, `rd_valid_o` is high and `rd_data_o` holds the counter value from before the edge that sampled the read.
- R9: A read with both `rd_priv0_i` and `user_rd_allow_i` low gives `rd_data_o` of zero, `rd_valid_o` low, and `rd_fault_o` high for exactly that one cycle.
- R10: Counters wrap modulo 2^40 and do not saturate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_cnt_i | input | 6 | Per-cycle event counts; bits 2:0 feed counter 0, bits 5:3 feed counter 1 |
| wr_en_i | input | 1 | Register write strobe |
| wr_priv0_i | input | 1 | Write comes from privilege level 0 |
| wr_addr_i | input | 2 | 0 = select 0, 1 = select 1, 2 = counter 0, 3 = counter 1 |
| wr_data_i | input | 32 | Write data |
| user_rd_allow_i | input | 1 | Allows non-privileged reads |
| rd_en_i | input | 1 | Read request |
| rd_priv0_i | input | 1 | Read comes from privilege level 0 |
| rd_sel_i | input | 1 | Counter index to read |
| rd_data_o | output | 40 | Read result, registered |
| rd_valid_o | output | 1 | Accepted read result present |
| rd_fault_o | output | 1 | One-cycle pulse for a rejected read |

## Verification
The bench builds the block with its default parameters: 40-bit counters, a 32-bit write field, 3-bit event inputs, and an 8-bit threshold at bit 24 with the enable at bit 22. With 3-bit events, thresholds of 3 and 5 split a short event pattern into qualifying and non-qualifying cycles. A preset of all ones in the low 32 bits sign-extends to a full 40-bit all-ones value, so the wrap past 2^40 is reached in a single counting cycle.

// File: rtl/evm_pkg.sv
package evm_pkg;
    localparam int NUM_CNT = 2;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    localparam logic [1:0] ADDR_SEL0 = 2'd0;
    localparam logic [1:0] ADDR_SEL1 = 2'd1;
    localparam logic [1:0] ADDR_CTR0 = 2'd2;
endpackage

// File: rtl/evm_counter_lane.sv
module evm_counter_lane #(
    parameter int CNT_W = 40,
    parameter int WR_W  = 32,
    parameter int EVT_W = 3,
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [THR_W-1:0] thr_i,
    input  logic [EVT_W-1:0] evt_i,
    input  logic             load_i,
    input  logic [WR_W-1:0]  load_val_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int EXT_W = CNT_W - WR_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] preset;
    logic [THR_W-1:0] evt_wide;

    always_comb begin
        evt_wide = {{(THR_W-EVT_W){1'b0}}, evt_i};
        if (thr_i == '0) begin
            step = {{(CNT_W-EVT_W){1'b0}}, evt_i};
        end else if (evt_wide >= thr_i) begin
            step = {{(CNT_W-1){1'b0}}, 1'b1};
        end else begin
            step = '0;
        end
        preset = {{EXT_W{load_val_i[WR_W-1]}}, load_val_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= preset;
        end else if (run_i) begin
            cnt_q <= cnt_q + step;
        end
    end

    assign cnt_o = cnt_q;

    // R3: a nonzero threshold never moves the count by more than one
    assert_thr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i && thr_i != '0) |=> ((cnt_q - $past(cnt_q)) <= 1));

    // R2: a zero threshold adds the raw event count
    assert_raw_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i && thr_i == '0) |=>
            (cnt_q == $past(cnt_q) + {{(CNT_W-EVT_W){1'b0}}, $past(evt_i)}));

    // R4: without run and without a load, the count holds
    assert_halt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(cnt_q));

    // R6: a load copies bit 31 into the upper bits
    assert_load_sext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> ((cnt_q[WR_W-1:0] == $past(load_val_i)) &&
                    ($past(load_val_i[WR_W-1]) ? (&cnt_q[CNT_W-1:WR_W-1])
                                               : !(|cnt_q[CNT_W-1:WR_W-1]))));
endmodule

// File: rtl/evm_ctrl_fsm.sv
module evm_ctrl_fsm
    import evm_pkg::*;
#(
    parameter int WR_W    = 32,
    parameter int THR_W   = 8,
    parameter int THR_LSB = 24,
    parameter int EN_BIT  = 22
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en_i,
    input  logic                           wr_priv0_i,
    input  logic [1:0]                     wr_addr_i,
    input  logic [WR_W-1:0]                wr_data_i,
    output logic [NUM_CNT-1:0]             run_o,
    output logic [NUM_CNT-1:0][THR_W-1:0]  thr_o,
    output logic [NUM_CNT-1:0]             load_o
);
    run_state_e                    state_q, state_d;
    logic [NUM_CNT-1:0][THR_W-1:0] thr_q;
    logic                          sel1_nz_q;
    logic                          wr_ok;
    logic                          sel0_wr;

    assign wr_ok   = wr_en_i && wr_priv0_i;
    assign sel0_wr = wr_ok && (wr_addr_i == ADDR_SEL0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (sel0_wr && wr_data_i[EN_BIT])  state_d = ST_RUN;
            ST_RUN:  if (sel0_wr && !wr_data_i[EN_BIT]) state_d = ST_HALT;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_HALT: run_o = '0;
            ST_RUN:  run_o = {sel1_nz_q, 1'b1};
        endcase
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_sel
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                thr_q[i] <= '0;
            end else if (wr_ok && wr_addr_i == 2'(i)) begin
                thr_q[i] <= wr_data_i[THR_LSB +: THR_W];
            end
        end
        assign load_o[i] = wr_ok && (wr_addr_i == ADDR_CTR0 + 2'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel1_nz_q <= 1'b0;
        end else if (wr_ok && wr_addr_i == ADDR_SEL1) begin
            sel1_nz_q <= |wr_data_i;
        end
    end

    assign thr_o = thr_q;

    // R7: an unprivileged write leaves control state untouched
    assert_nonpriv_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_priv0_i) |=> ($stable(state_q) && $stable(thr_q) && $stable(sel1_nz_q)));

    // R4: a privileged enable write puts counter 0 into run on the next cycle
    assert_en_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel0_wr && wr_data_i[EN_BIT]) |=> run_o[0]);

    // R4: clearing enable halts both counters
    assert_en_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel0_wr && !wr_data_i[EN_BIT]) |=> (run_o == '0));
endmodule

// File: rtl/evm_read_port.sv
module evm_read_port
    import evm_pkg::*;
#(
    parameter int CNT_W = 40
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en_i,
    input  logic                          rd_priv0_i,
    input  logic                          user_rd_allow_i,
    input  logic                          rd_sel_i,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0]              rd_data_o,
    output logic                          rd_valid_o,
    output logic                          rd_fault_o
);
    logic allowed;

    assign allowed = rd_priv0_i || user_rd_allow_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
            rd_fault_o <= 1'b0;
        end else begin
            rd_valid_o <= rd_en_i && allowed;
            rd_fault_o <= rd_en_i && !allowed;
            rd_data_o  <= (rd_en_i && allowed) ? cnt_i[rd_sel_i] : '0;
        end
    end

    // R9: a fault carries no data and no valid
    assert_fault_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fault_o |-> (rd_data_o == '0 && !rd_valid_o));

    // R9: a blocked user read faults on the next cycle
    assert_user_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !rd_priv0_i && !user_rd_allow_i) |=> rd_fault_o);

    // R8: a privileged read always completes with the pre-edge value
    assert_priv_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_priv0_i) |=> (rd_valid_o && !rd_fault_o &&
                                     rd_data_o == $past(cnt_i[rd_sel_i])));
endmodule

// File: rtl/evm_top.sv
module evm_top
    import evm_pkg::*;
#(
    parameter int CNT_W   = 40,
    parameter int WR_W    = 32,
    parameter int EVT_W   = 3,
    parameter int THR_W   = 8,
    parameter int THR_LSB = 24,
    parameter int EN_BIT  = 22
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CNT*EVT_W-1:0] evt_cnt_i,
    input  logic                     wr_en_i,
    input  logic                     wr_priv0_i,
    input  logic [1:0]               wr_addr_i,
    input  logic [WR_W-1:0]          wr_data_i,
    input  logic                     user_rd_allow_i,
    input  logic                     rd_en_i,
    input  logic                     rd_priv0_i,
    input  logic                     rd_sel_i,
    output logic [CNT_W-1:0]         rd_data_o,
    output logic                     rd_valid_o,
    output logic                     rd_fault_o
);
    logic [NUM_CNT-1:0]             run;
    logic [NUM_CNT-1:0]             load;
    logic [NUM_CNT-1:0][THR_W-1:0]  thr;
    logic [NUM_CNT-1:0][CNT_W-1:0]  cnt;

    evm_ctrl_fsm #(
        .WR_W   (WR_W),
        .THR_W  (THR_W),
        .THR_LSB(THR_LSB),
        .EN_BIT (EN_BIT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_priv0_i(wr_priv0_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .run_o     (run),
        .thr_o     (thr),
        .load_o    (load)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_lane
        evm_counter_lane #(
            .CNT_W(CNT_W),
            .WR_W (WR_W),
            .EVT_W(EVT_W),
            .THR_W(THR_W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_i     (run[i]),
            .thr_i     (thr[i]),
            .evt_i     (evt_cnt_i[i*EVT_W +: EVT_W]),
            .load_i    (load[i]),
            .load_val_i(wr_data_i),
            .cnt_o     (cnt[i])
        );
    end

    evm_read_port #(
        .CNT_W(CNT_W)
    ) u_rd (
        .clk            (clk),
        .rst_n          (rst_n),
        .rd_en_i        (rd_en_i),
        .rd_priv0_i     (rd_priv0_i),
        .user_rd_allow_i(user_rd_allow_i),
        .rd_sel_i       (rd_sel_i),
        .cnt_i          (cnt),
        .rd_data_o      (rd_data_o),
        .rd_valid_o     (rd_valid_o),
        .rd_fault_o     (rd_fault_o)
    );

    // R5: counter 1 stays put whenever its lane is gated off, while counter 0 may run
    assert_sel1_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run[1] && !load[1]) |=> $stable(cnt[1]));
endmodule

// File: tb/evm_top_tb_top.sv
module evm_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] EN = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  evt_cnt_i = '0;
    logic        wr_en_i = 1'b0;
    logic        wr_priv0_i = 1'b0;
    logic [1:0]  wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic        user_rd_allow_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic        rd_priv0_i = 1'b0;
    logic        rd_sel_i = 1'b0;
    logic [39:0] rd_data_o;
    logic        rd_valid_o;
    logic        rd_fault_o;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evm_top dut_i (
        .clk(clk), .rst_n(rst_n), .evt_cnt_i(evt_cnt_i),
        .wr_en_i(wr_en_i), .wr_priv0_i(wr_priv0_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .user_rd_allow_i(user_rd_allow_i),
        .rd_en_i(rd_en_i), .rd_priv0_i(rd_priv0_i), .rd_sel_i(rd_sel_i),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .rd_fault_o(rd_fault_o)
    );

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_evt(input logic [2:0] e0, input logic [2:0] e1);
        evt_cnt_i = {e1, e0};
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic priv);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d; wr_priv0_i = priv;
        @(negedge clk);
        wr_en_i = 1'b0; wr_priv0_i = 1'b0;
    endtask

    task automatic run_evt(input logic [2:0] e0, input logic [2:0] e1, input int n);
        set_evt(e0, e1);
        repeat (n) @(negedge clk);
        set_evt(0, 0);
    endtask

    task automatic rd(input logic idx, input logic priv,
                      output logic [39:0] d, output logic v, output logic f);
        rd_en_i = 1'b1; rd_sel_i = idx; rd_priv0_i = priv;
        @(negedge clk);
        rd_en_i = 1'b0; rd_priv0_i = 1'b0;
        d = rd_data_o; v = rd_valid_o; f = rd_fault_o;
    endtask

    task automatic expect_ctr(input string req, input logic idx, input logic [39:0] exp);
        logic [39:0] d; logic v, f;
        rd(idx, 1'b1, d, v, f);
        chk(req, d, exp);
    endtask

    task automatic t_reset();
        chk("R1 valid", {39'd0, rd_valid_o}, 40'd0);
        chk("R1 fault", {39'd0, rd_fault_o}, 40'd0);
        expect_ctr("R1 ctr0", 1'b0, 40'd0);
        expect_ctr("R1 ctr1", 1'b1, 40'd0);
    endtask

    task automatic t_enable_start();
        wr(2'd1, 32'h0001_0000, 1'b1);
        set_evt(3, 2);
        wr(2'd0, EN, 1'b1);          // write edge: no count (R4)
        @(negedge clk);              // next edge counts once
        set_evt(0, 0);
        expect_ctr("R4 start ctr0", 1'b0, 40'd3);
        expect_ctr("R4 start ctr1", 1'b1, 40'd2);
    endtask

    task automatic t_raw();
        wr(2'd2, 32'd0, 1'b1);
        wr(2'd3, 32'd0, 1'b1);
        run_evt(7, 1, 5);
        expect_ctr("R2 raw ctr0", 1'b0, 40'd35);
        expect_ctr("R2 raw ctr1", 1'b1, 40'd5);
    endtask

    task automatic t_threshold();
        logic [2:0] pat [6] = '{3'd2, 3'd3, 3'd7, 3'd0, 3'd4, 3'd3};
        wr(2'd0, EN | 32'h0300_0000, 1'b1);
        wr(2'd1, 32'h0500_0000, 1'b1);
        wr(2'd2, 32'd0, 1'b1);
        wr(2'd3, 32'd0, 1'b1);
        for (int k = 0; k < 6; k++) begin
            set_evt(pat[k], pat[k]);
            @(negedge clk);
        end
        set_evt(0, 0);
        expect_ctr("R3 thr3 ctr0", 1'b0, 40'd4);
        expect_ctr("R3 thr5 ctr1", 1'b1, 40'd1);
    endtask

    task automatic t_sel1_zero();
        wr(2'd1, 32'd0, 1'b1);
        wr(2'd0, EN, 1'b1);
        wr(2'd2, 32'd0, 1'b1);
        wr(2'd3, 32'd0, 1'b1);
        run_evt(2, 2, 3);
        expect_ctr("R5 ctr0 runs", 1'b0, 40'd6);
        expect_ctr("R5 ctr1 held", 1'b1, 40'd0);
    endtask

    task automatic t_disable();
        wr(2'd1, 32'h0001_0000, 1'b1);
        wr(2'd0, 32'd0, 1'b1);
        run_evt(4, 4, 3);
        expect_ctr("R4 stop ctr0", 1'b0, 40'd6);
        expect_ctr("R4 stop ctr1", 1'b1, 40'd0);
    endtask

    task automatic t_sext_wrap();
        wr(2'd2, 32'h8000_0000, 1'b1);
        expect_ctr("R6 neg sext", 1'b0, 40'hFF_8000_0000);
        wr(2'd3, 32'h7FFF_FFFF, 1'b1);
        expect_ctr("R6 pos sext", 1'b1, 40'h00_7FFF_FFFF);
        wr(2'd0, EN, 1'b1);
        wr(2'd2, 32'hFFFF_FFFF, 1'b1);
        run_evt(2, 0, 1);
        expect_ctr("R10 wrap", 1'b0, 40'd1);
        set_evt(5, 0);
        wr(2'd2, 32'h0000_0010, 1'b1);
        set_evt(0, 0);
        expect_ctr("R6 write wins", 1'b0, 40'h10);
    endtask

    task automatic t_priv();
        wr(2'd2, 32'h55, 1'b0);
        wr(2'd0, 32'd0, 1'b0);
        run_evt(1, 0, 2);
        expect_ctr("R7 ignored writes", 1'b0, 40'h12);
    endtask

    task automatic t_read();
        logic [39:0] d; logic v, f;
        user_rd_allow_i = 1'b1;
        rd(1'b0, 1'b0, d, v, f);
        chk("R8 user data", d, 40'h12);
        chk("R8 user valid", {39'd0, v}, 40'd1);
        user_rd_allow_i = 1'b0;
        rd(1'b1, 1'b0, d, v, f);
        chk("R9 data zero", d, 40'd0);
        chk("R9 no valid", {39'd0, v}, 40'd0);
        chk("R9 fault", {39'd0, f}, 40'd1);
        @(negedge clk);
        chk("R9 one cycle", {39'd0, rd_fault_o}, 40'd0);
        rd(1'b1, 1'b1, d, v, f);
        chk("R8 priv data", d, 40'h00_7FFF_FFFF);
        chk("R8 priv valid", {39'd0, v}, 40'd1);
        set_evt(1, 0);
        rd(1'b0, 1'b1, d, v, f);
        set_evt(0, 0);
        chk("R8 pre-update", d, 40'h12);
        expect_ctr("R8 after", 1'b0, 40'h13);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_start();
        t_raw();
        t_threshold();
        t_sel1_zero();
        t_disable();
        t_sext_wrap();
        t_priv();
        t_read();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule